// File: doc/BRIEF.md
# Per-Processor Interrupt Front End

This block sits between a shared interrupt distributor and a single processor. Each cycle the distributor offers its best candidate interrupt: an ID, a priority and, for inter-processor interrupts, the number of the CPU that raised it. The block compares that candidate against a software-programmed priority mask and against the priority of the interrupt currently being serviced. It drives a registered interrupt request line when the candidate may preempt the processor and signalling is enabled.

Software talks to the block through a simple word-addressed register bus. Reading the claim register takes ownership of the candidate. The read returns the ID together with the source CPU number, the block raises its running priority to that of the claimed interrupt, and it sends a one-cycle claim strobe to the distributor. Writing the same word to the completion register retires the interrupt. The block then drops the running priority back to idle and sends a completion strobe. A claim read that finds nothing eligible returns the reserved "nothing pending" ID and changes no state. Running priority and the highest pending candidate can also be read back.

Top module: `intr_cpu_if`

## Requirements
- R1: After reset irq_o is 0, the control register reads 0, the priority mask reads 0 and the running priority reads 0xFF. No claim or completion strobe is asserted.
- R2: irq_o is a registered output. It is 1 in the cycle after an edge at which the control bit 0 was 1 and the candidate was eligible. It stays 0 whenever control bit 0 is 0.
- R3: A candidate is eligible only if cand_valid_i is 1, its ID is below 1022, and its priority value is strictly lower than the 8-bit mask. With a mask of 0xFF every priority except 0xFF passes, and a mask of 0 blocks everything.
- R4: A claim read (offset 2) of an eligible candidate returns the ID in bits 9:0. For IDs 0 to 15 it also returns the source CPU in bits 12:10; for other IDs those bits are 0. In the next cycle ack_o is 1 with ack_id_o equal to the ID, and the running priority equals the candidate's priority. The claim is independent of control bit 0.
- R5: A claim read with no eligible candidate returns 1023. This covers an invalid candidate, a spurious ID of 1022 or 1023, a masked candidate and a candidate blocked by the running priority. Such a read asserts no ack_o and leaves the running priority unchanged.
- R6: While an interrupt is claimed, a candidate is eligible only if its priority value is also strictly lower than the running priority.
- R7: Writing the claimed word to the completion register (offset 3) pulses eoi_o in the next cycle with eoi_id_o equal to the ID, and returns the running priority to 0xFF.
- R8: A completion write whose ID or source field does not match the claimed interrupt, or a write made when nothing is claimed, asserts no eoi_o and leaves the running priority unchanged.
- R9: The highest-pending register (offset 5) returns the valid, non-spurious candidate in the claim layout regardless of mask and running priority. Otherwise it returns 1023. Reading it has no side effect.
- R10: The register map is: offset 0 control (bit 0), offset 1 mask (bits 7:0), offset 2 claim, offset 3 completion, offset 4 running priority (bits 7:0), offset 5 highest pending. Writes to offsets 2, 4 and 5 have no effect, and offset 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_src_i | input | 3 | Source CPU of an inter-processor candidate |
| cand_prio_i | input | 8 | Candidate priority (lower value is more urgent) |
| reg_req_i | input | 1 | Register access in this cycle |
| reg_we_i | input | 1 | Access is a write |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | One-cycle claim strobe to the distributor |
| ack_id_o | output | 10 | ID that was claimed |
| eoi_o | output | 1 | One-cycle completion strobe to the distributor |
| eoi_id_o | output | 10 | ID that was completed |

## Verification
A corrupted running priority shows within one cycle. Either irq_o stays low for a candidate that should preempt, or a claim read returns 1023 where a real ID was expected. Reading offset 4 exposes the value directly. A wrong claimed-ID record shows at the next completion write as a missing eoi_o, or as an eoi_id_o that differs from the claimed ID. The bench therefore completes every claim and checks both strobes and the restored priority before it moves on. A wrong eligibility compare shows as a wrong irq_o one cycle after the candidate settles. The table rows sit on the mask boundary (equal and one below), on spurious IDs and on the inter-processor ID range, so that off-by-one compares are caught.

// File: rtl/intr_cpu_if_pkg.sv
package intr_cpu_if_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_PMASK  = 3'd1,
    REG_CLAIM  = 3'd2,
    REG_DONE   = 3'd3,
    REG_RUNPRI = 3'd4,
    REG_HPPEND = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/cpuif_cfg_regs.sv
module cpuif_cfg_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_mask_i,
  input  logic              en_d_i,
  input  logic [PRIO_W-1:0] mask_d_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= '0;
    end else begin
      if (wr_ctrl_i) en_o   <= en_d_i;
      if (wr_mask_i) mask_o <= mask_d_i;
    end
  end
endmodule

// File: rtl/cpuif_qualify.sv
module cpuif_qualify #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic [PRIO_W-1:0] running_i,
  output logic              real_o,
  output logic              pass_o
);
  localparam logic [ID_W-1:0] SPUR_LO = ID_W'((1 << ID_W) - 2);

  assign real_o = cand_valid_i && (cand_id_i < SPUR_LO);
  assign pass_o = real_o && (cand_prio_i < mask_i) && (cand_prio_i < running_i);
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int ID_W   = 10,
  parameter int SRC_W  = 3,
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              claim_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [SRC_W-1:0]  cand_src_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              done_wr_i,
  input  logic [ID_W-1:0]   done_id_i,
  input  logic [SRC_W-1:0]  done_src_i,
  output logic [PRIO_W-1:0] running_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam logic [PRIO_W-1:0] IDLE = '1;

  logic             act_q;
  logic [ID_W-1:0]  act_id_q;
  logic [SRC_W-1:0] act_src_q;
  logic             retire;

  assign retire = done_wr_i && act_q && !claim_i &&
                  (done_id_i == act_id_q) && (done_src_i == act_src_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      act_id_q  <= '0;
      act_src_q <= '0;
      running_o <= IDLE;
      ack_o     <= 1'b0;
      ack_id_o  <= '0;
      eoi_o     <= 1'b0;
      eoi_id_o  <= '0;
    end else begin
      ack_o <= claim_i;
      eoi_o <= retire;
      if (claim_i) begin
        // single slot: a preempting claim replaces the record
        act_q     <= 1'b1;
        act_id_q  <= cand_id_i;
        act_src_q <= cand_src_i;
        running_o <= cand_prio_i;
        ack_id_o  <= cand_id_i;
      end else if (retire) begin
        act_q     <= 1'b0;
        running_o <= IDLE;
        eoi_id_o  <= act_id_q;
      end
    end
  end
endmodule

// File: rtl/intr_cpu_if.sv
module intr_cpu_if
  import intr_cpu_if_pkg::*;
#(
  parameter int ID_W    = 10,
  parameter int SRC_W   = 3,
  parameter int PRIO_W  = 8,
  parameter int SGI_NUM = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [SRC_W-1:0]  cand_src_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam int          WORD_W   = ID_W + SRC_W;
  localparam logic [ID_W-1:0] SPUR_ID = '1;

  logic              en_q, cand_real, cand_pass, claim, wr_ctrl, wr_mask, done_wr;
  logic [PRIO_W-1:0] mask_q, running;
  logic [SRC_W-1:0]  cand_src_f;
  logic [WORD_W-1:0] cand_word, spur_word;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:WORD_W];
  assign cand_src_f   = (32'(cand_id_i) < SGI_NUM) ? cand_src_i : '0;
  assign cand_word    = {cand_src_f, cand_id_i};
  assign spur_word    = {{SRC_W{1'b0}}, SPUR_ID};

  assign wr_ctrl = reg_req_i && reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_mask = reg_req_i && reg_we_i && (reg_addr_i == REG_PMASK);
  assign done_wr = reg_req_i && reg_we_i && (reg_addr_i == REG_DONE);
  assign claim   = reg_req_i && !reg_we_i && (reg_addr_i == REG_CLAIM) && cand_pass;

  cpuif_cfg_regs #(.PRIO_W(PRIO_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_ctrl_i (wr_ctrl),
    .wr_mask_i (wr_mask),
    .en_d_i    (reg_wdata_i[0]),
    .mask_d_i  (reg_wdata_i[PRIO_W-1:0]),
    .en_o      (en_q),
    .mask_o    (mask_q)
  );

  cpuif_qualify #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_qual (
    .cand_valid_i, .cand_id_i, .cand_prio_i,
    .mask_i    (mask_q),
    .running_i (running),
    .real_o    (cand_real),
    .pass_o    (cand_pass)
  );

  cpuif_active #(.ID_W(ID_W), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_act (
    .clk_i, .rst_ni,
    .claim_i     (claim),
    .cand_id_i, 
    .cand_src_i  (cand_src_f),
    .cand_prio_i,
    .done_wr_i   (done_wr),
    .done_id_i   (reg_wdata_i[ID_W-1:0]),
    .done_src_i  (reg_wdata_i[WORD_W-1:ID_W]),
    .running_o   (running),
    .ack_o, .ack_id_o, .eoi_o, .eoi_id_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= en_q && cand_pass;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL:   reg_rdata_o = DATA_W'(en_q);
      REG_PMASK:  reg_rdata_o = DATA_W'(mask_q);
      REG_CLAIM:  reg_rdata_o = DATA_W'(cand_pass ? cand_word : spur_word);
      REG_RUNPRI: reg_rdata_o = DATA_W'(running);
      REG_HPPEND: reg_rdata_o = DATA_W'(cand_real ? cand_word : spur_word);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intr_cpu_if_chk.sv
module intr_cpu_if_chk #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [PRIO_W-1:0] mask_i,
  input logic [PRIO_W-1:0] cand_prio_i,
  input logic [PRIO_W-1:0] running_i,
  input logic              irq_i,
  input logic              ack_i,
  input logic [ID_W-1:0]   ack_id_i,
  input logic              eoi_i
);
  localparam logic [ID_W-1:0] SPUR_LO = ID_W'((1 << ID_W) - 2);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_i); // R2
  AST_IRQ_BELOW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(cand_prio_i < mask_i)); // R3
  AST_CLAIM_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (running_i != '1)); // R4
  AST_CLAIM_NOT_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (ack_id_i < SPUR_LO)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i |-> (running_i == '1)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && eoi_i)); // R7
  AST_RUN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !eoi_i) |-> $stable(running_i)); // R8
endmodule

bind intr_cpu_if intr_cpu_if_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_q),
  .mask_i      (mask_q),
  .cand_prio_i (cand_prio_i),
  .running_i   (running),
  .irq_i       (irq_o),
  .ack_i       (ack_o),
  .ack_id_i    (ack_id_o),
  .eoi_i       (eoi_o)
);

// File: tb/intr_cpu_if_tb.sv
module intr_cpu_if_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [2:0]  cand_src = '0;
  logic [7:0]  cand_prio = '0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, ack, eoi;
  logic [9:0]  ack_id, eoi_id;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_cpu_if u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_src_i(cand_src),
    .cand_prio_i(cand_prio),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id), .eoi_o(eoi), .eoi_id_o(eoi_id)
  );

  typedef struct packed {
    logic       en;
    logic [7:0] mask;
    logic       valid;
    logic [9:0] id;
    logic [2:0] src;
    logic [7:0] prio;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hFF, 1'b1, 10'd40,   3'd5, 8'h10},
    '{1'b1, 8'hFF, 1'b1, 10'd3,    3'd5, 8'h80},
    '{1'b0, 8'hFF, 1'b1, 10'd50,   3'd0, 8'h10},
    '{1'b1, 8'h20, 1'b1, 10'd60,   3'd0, 8'h20},
    '{1'b1, 8'h21, 1'b1, 10'd60,   3'd0, 8'h20},
    '{1'b1, 8'h00, 1'b1, 10'd7,    3'd1, 8'h00},
    '{1'b1, 8'hFF, 1'b1, 10'd1022, 3'd0, 8'h00},
    '{1'b1, 8'hFF, 1'b0, 10'd30,   3'd0, 8'h05},
    '{1'b1, 8'hFF, 1'b1, 10'd1021, 3'd7, 8'hFE}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_req = 0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] word_of(input logic [9:0] id, input logic [2:0] src);
    return {19'd0, (id < 10'd16) ? src : 3'd0, id};
  endfunction

  task automatic set_cand(input logic v, input logic [9:0] id, input logic [2:0] s, input logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_src = s; cand_prio = p;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq == 0 && ack == 0 && eoi == 0, "R1 outputs", {irq, ack, eoi}, 0);
    rst_ni = 1;
    rd(3'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(3'd1, d); chk(d == 0, "R1 mask", d, 0);
    rd(3'd4, d); chk(d == 32'hFF, "R1 runpri", d, 32'hFF);
    // R3 mask 0 blocks everything
    set_cand(1, 10'd9, 0, 8'h00); wr(3'd0, 1); settle();
    chk(irq == 0, "R3 zero mask", irq, 0);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VEC[i];
      automatic bit q = v.valid && v.id < 10'd1022 && v.prio < v.mask;
      automatic logic [31:0] ew = q ? word_of(v.id, v.src) : 32'd1023;
      set_cand(v.valid, v.id, v.src, v.prio);
      wr(3'd0, {31'd0, v.en});
      wr(3'd1, {24'd0, v.mask});
      settle();
      chk(irq == (v.en && q), $sformatf("R2/R3 irq row %0d", i), irq, v.en && q);
      rd(3'd2, w);
      chk(w == ew, $sformatf("R4/R5 claim row %0d", i), w, ew);
      chk(ack == q, $sformatf("R4 ack strobe row %0d", i), ack, q);
      if (q) chk(ack_id == v.id, $sformatf("R4 ack id row %0d", i), ack_id, v.id);
      rd(3'd4, d);
      chk(d == (q ? v.prio : 8'hFF), $sformatf("R4/R5 runpri row %0d", i), d, q ? v.prio : 8'hFF);
      if (q) begin
        settle();
        chk(irq == 0, $sformatf("R6 irq drop row %0d", i), irq, 0);
        wr(3'd3, w);
        chk(eoi == 1 && eoi_id == v.id, $sformatf("R7 eoi row %0d", i), {eoi, eoi_id}, {1'b1, v.id});
        rd(3'd4, d);
        chk(d == 32'hFF, $sformatf("R7 runpri idle row %0d", i), d, 32'hFF);
      end
    end

    // R6 running priority gating
    wr(3'd0, 1); wr(3'd1, 32'hFF);
    set_cand(1, 10'd100, 0, 8'h40);
    rd(3'd2, w); chk(w == 100, "R6 first claim", w, 100);
    set_cand(1, 10'd101, 0, 8'h40); settle();
    chk(irq == 0, "R6 equal to running", irq, 0);
    rd(3'd2, d); chk(d == 1023, "R6 claim blocked", d, 1023);
    chk(ack == 0, "R5 no strobe blocked", ack, 0);
    // R9 highest pending ignores running/mask
    rd(3'd5, d); chk(d == 101, "R9 hppend", d, 101);
    set_cand(1, 10'd102, 0, 8'h3F); settle();
    chk(irq == 1, "R6 more urgent", irq, 1);
    rd(3'd2, w); chk(w == 102, "R6 preempt claim", w, 102);

    // R8 mismatched completion
    wr(3'd3, 32'd100);
    chk(eoi == 0, "R8 mismatch eoi", eoi, 0);
    rd(3'd4, d); chk(d == 32'h3F, "R8 runpri kept", d, 32'h3F);
    // R10 writes to read-only offsets ignored, completion reads 0
    wr(3'd4, 32'hFF); wr(3'd5, 0); wr(3'd2, 0);
    rd(3'd4, d); chk(d == 32'h3F, "R10 runpri ro", d, 32'h3F);
    rd(3'd3, d); chk(d == 0, "R10 done reads 0", d, 0);
    wr(3'd3, 32'd102);
    chk(eoi == 1 && eoi_id == 102, "R7 eoi after preempt", {eoi, eoi_id}, {1'b1, 10'd102});
    wr(3'd3, 32'd102);
    chk(eoi == 0, "R8 nothing claimed", eoi, 0);
    // R8 source field mismatch on an inter-processor ID
    set_cand(1, 10'd2, 3'd6, 8'h01);
    rd(3'd2, w); chk(w == 32'h1802, "R4 sgi src", w, 32'h1802);
    wr(3'd3, 32'h0802);
    chk(eoi == 0, "R8 src mismatch", eoi, 0);
    wr(3'd3, w);
    chk(eoi == 1, "R7 src match", eoi, 1);
    // R9 spurious / invalid
    set_cand(1, 10'd1023, 0, 0);
    rd(3'd5, d); chk(d == 1023, "R9 spurious", d, 1023);
    set_cand(0, 10'd5, 0, 0);
    rd(3'd5, d); chk(d == 1023, "R9 invalid", d, 1023);
    // R2 disable drops irq
    set_cand(1, 10'd200, 0, 8'h10); settle();
    chk(irq == 1, "R2 enabled", irq, 1);
    wr(3'd0, 0); settle();
    chk(irq == 0, "R2 disabled", irq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule